// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Controller

This block sweeps the integer divider setting of a frequency synthesiser along a triangular profile, so that the synthesised clock spreads its energy over a narrow band rather than sitting on one frequency. A 2-bit mode field chooses plain operation, test mode, spreading, or output tri-state. A 3-bit spread code chooses the profile. Codes with the top bit clear swing symmetrically above and below the nominal divider. Codes with the top bit set swing only downward from it. Each pulse on the modulation tick input moves the profile one step.

The block registers the mode and spread code. It decodes them into the two status flags, the sweep direction and a fixed-point width fraction. It keeps a phase counter for the triangle and scales the triangle by the nominal divider and the width fraction, rounding the result to the nearest integer. Any change of mode or spread code sends the profile back to the nominal value.

Top module: `spread_profile_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `div_out` equals `nominal_div` and `spread_active`, `test_mode` and `outputs_tristate` are all 0.
- R2: One clock edge after `mode_sel` is applied, the flags decode it as follows: 00 sets no flag, 01 sets only `test_mode`, 10 sets only `spread_active`, 11 sets only `outputs_tristate`. At most one flag is ever high.
- R3: While the registered mode is not 10, `div_out` equals `nominal_div`, and neither `mod_tick` nor `spread_code` changes it.
- R4: In mode 10 the phase q (0 to 4H-1, with H = 2^HALF_LOG2 = 8, so 32 ticks per period) advances by one at every clock edge where `mod_tick` is 1 and the configuration is unchanged. After 4H-1 it wraps to 0.
- R5: For down codes (`spread_code[2]` = 1), `div_out` = nominal - round(nominal·F·t / (2H·2^16)), where t = q for q ≤ 2H and t = 4H - q otherwise. `div_out` never exceeds `nominal_div`.
- R6: For centre codes (`spread_code[2]` = 0), s = q for q ≤ H, s = 2H - q for H < q ≤ 3H, and s = q - 4H otherwise. `div_out` = nominal + sign(s)·round(nominal·F·|s| / (2H·2^16)), so the peak swing is half the total width on each side.
- R7: The total-width fraction F is selected by `spread_code[1:0]` with F = round(bp·2^16/10000): 00 gives 1.5 % (F = 983), 01 gives 1.0 % (655), 10 gives 0.7 % (459) and 11 gives 0.5 % (328). Rounding is half up throughout.
- R8: If `mode_sel` or `spread_code` differs from the registered value at a clock edge, the phase returns to 0 at that edge, so `div_out` equals the nominal value afterwards. A tick in that same cycle is ignored, and the next tick moves to q = 1.
- R9: A change of `nominal_div` during spreading changes `div_out` in the same cycle using the current phase, without restarting the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode field: 00 plain, 01 test, 10 spread, 11 tri-state |
| spread_code | input | 3 | Spread profile code (bit 2: 1 down, 0 centre; bits 1:0 width) |
| nominal_div | input | DIV_W (12) | Nominal divider value |
| mod_tick | input | 1 | Modulation step strobe, one step per high cycle |
| div_out | output | DIV_W (12) | Instantaneous divider setting |
| spread_active | output | 1 | Registered mode is spreading |
| test_mode | output | 1 | Registered mode is test mode |
| outputs_tristate | output | 1 | Registered mode requests tri-state of all outputs |

## Verification
A phase counter that drifts, skips or wraps in the wrong place shows up as a wrong `div_out` at the sample taken right after the tick concerned. The error is visible at the very first tick, because the first step already moves the divider for nominal values of a few thousand. A wrong width fraction, or a swapped direction decode, gives a wrong deviation by the second tick of the sweep. The deviation at the peak phases also exposes an off-by-one in the rounding. A restart that is missed or comes one edge late leaves a non-nominal `div_out` in the cycle right after the configuration change, and the bench samples exactly that cycle.

// File: rtl/spread_pkg.sv
`timescale 1ns/1ps
package spread_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SPREAD = 2'b10,
        MODE_HIZ    = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e      mode;
        logic [2:0] code;
    } cfg_t;

    typedef struct packed {
        logic test;
        logic spread;
        logic hiz;
        logic down;
    } flags_t;

    localparam cfg_t CFG_RESET = '{mode: MODE_PLAIN, code: 3'b111};

    // Widths are held in units of 0.01 percent.
    localparam longint BP_SCALE = 10000;

    function automatic longint width_bp(input logic [1:0] idx);
        case (idx)
            2'd0:    return 150;
            2'd1:    return 100;
            2'd2:    return 70;
            default: return 50;
        endcase
    endfunction

    // Fixed-point fraction of the total width, rounded half up.
    function automatic longint width_frac(input logic [1:0] idx, input int frac_w);
        longint num;
        num = width_bp(idx) * (longint'(1) << frac_w) + BP_SCALE / 2;
        return num / BP_SCALE;
    endfunction

endpackage

// File: rtl/spread_decode.sv
`timescale 1ns/1ps
module spread_decode
    import spread_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  cfg_t              cfg,
    output flags_t            flags,
    output logic [FRAC_W-1:0] frac
);
    localparam int N_WIDTHS = 4;

    logic [FRAC_W-1:0] frac_tab [N_WIDTHS];

    for (genvar i = 0; i < N_WIDTHS; i++) begin : g_tab
        localparam longint FV = width_frac(2'(i), FRAC_W);
        assign frac_tab[i] = FRAC_W'(FV);
    end

    always_comb begin
        flags.test   = (cfg.mode == MODE_TEST);
        flags.spread = (cfg.mode == MODE_SPREAD);
        flags.hiz    = (cfg.mode == MODE_HIZ);
        flags.down   = cfg.code[2];
        frac         = frac_tab[cfg.code[1:0]];
    end

endmodule

// File: rtl/spread_sweep.sv
`timescale 1ns/1ps
module spread_sweep #(
    parameter int HALF_LOG2 = 3,
    localparam int PH_W     = HALF_LOG2 + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            run_en,
    input  logic            tick,
    input  logic            down,
    output logic [PH_W-1:0] mag,
    output logic            neg
);
    localparam int HALF = 1 << HALF_LOG2;
    localparam logic [PH_W-1:0] Q_H  = PH_W'(HALF);
    localparam logic [PH_W-1:0] Q_2H = PH_W'(2 * HALF);
    localparam logic [PH_W-1:0] Q_3H = PH_W'(3 * HALF);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run_en && tick) begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    // Triangle shaping; '0 - phase gives 4H - phase modulo the counter width.
    always_comb begin
        if (down) begin
            neg = 1'b1;
            mag = (phase_q <= Q_2H) ? phase_q : ('0 - phase_q);
        end else if (phase_q <= Q_H) begin
            neg = 1'b0;
            mag = phase_q;
        end else if (phase_q <= Q_2H) begin
            neg = 1'b0;
            mag = Q_2H - phase_q;
        end else if (phase_q <= Q_3H) begin
            neg = 1'b1;
            mag = phase_q - Q_2H;
        end else begin
            neg = 1'b1;
            mag = '0 - phase_q;
        end
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == '0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !restart) |=> $stable(phase_q)); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick && !restart) |=> (phase_q == PH_W'($past(phase_q) + PH_W'(1)))); // R4

    AST_MAG_LIMIT: assert property (@(posedge clk) disable iff (rst)
        mag <= Q_2H); // R5

endmodule

// File: rtl/spread_scale.sv
`timescale 1ns/1ps
module spread_scale #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 16,
    parameter int MAG_W  = 5,
    parameter int SHIFT  = 20
) (
    input  logic [DIV_W-1:0]  nominal,
    input  logic [FRAC_W-1:0] frac,
    input  logic [MAG_W-1:0]  mag,
    input  logic              neg,
    input  logic              active,
    output logic [DIV_W-1:0]  div
);
    localparam int PROD_W = DIV_W + FRAC_W + MAG_W + 1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] rounded;
    logic [DIV_W-1:0]  dev;

    always_comb begin
        prod    = PROD_W'(nominal) * PROD_W'(frac) * PROD_W'(mag);
        rounded = prod + (PROD_W'(1) << (SHIFT - 1));
        dev     = DIV_W'(rounded >> SHIFT);
        if (!active) begin
            div = nominal;
        end else if (neg) begin
            div = nominal - dev;
        end else begin
            div = nominal + dev;
        end
    end

endmodule

// File: rtl/spread_profile_ctrl.sv
`timescale 1ns/1ps
module spread_profile_ctrl
    import spread_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int HALF_LOG2 = 3,
    parameter int FRAC_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic [2:0]       spread_code,
    input  logic [DIV_W-1:0] nominal_div,
    input  logic             mod_tick,
    output logic [DIV_W-1:0] div_out,
    output logic             spread_active,
    output logic             test_mode,
    output logic             outputs_tristate
);
    localparam int MAG_W = HALF_LOG2 + 2;
    localparam int SHIFT = FRAC_W + HALF_LOG2 + 1;

    cfg_t              cfg_in;
    cfg_t              cfg_q;
    logic              cfg_change;
    flags_t            flags;
    logic [FRAC_W-1:0] frac;
    logic [MAG_W-1:0]  mag;
    logic              neg;

    assign cfg_in     = '{mode: mode_e'(mode_sel), code: spread_code};
    assign cfg_change = (cfg_in != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_in;
        end
    end

    spread_decode #(.FRAC_W(FRAC_W)) u_decode (
        .cfg   (cfg_q),
        .flags (flags),
        .frac  (frac)
    );

    spread_sweep #(.HALF_LOG2(HALF_LOG2)) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_change),
        .run_en  (flags.spread),
        .tick    (mod_tick),
        .down    (flags.down),
        .mag     (mag),
        .neg     (neg)
    );

    spread_scale #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W),
        .MAG_W  (MAG_W),
        .SHIFT  (SHIFT)
    ) u_scale (
        .nominal (nominal_div),
        .frac    (frac),
        .mag     (mag),
        .neg     (neg),
        .active  (flags.spread),
        .div     (div_out)
    );

    assign spread_active    = flags.spread;
    assign test_mode        = flags.test;
    assign outputs_tristate = flags.hiz;

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0({test_mode, spread_active, outputs_tristate})); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !spread_active |-> (div_out == nominal_div)); // R3

    AST_DOWN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (spread_active && cfg_q.code[2]) |-> (div_out <= nominal_div)); // R5

    AST_RESTART_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        cfg_change |=> (div_out == nominal_div)); // R8

endmodule

// File: tb/spread_profile_ctrl_tb.sv
`timescale 1ns/1ps
module spread_profile_ctrl_tb;
    localparam int DW   = 12;
    localparam int HL   = 3;
    localparam int FW   = 16;
    localparam int H    = 1 << HL;
    localparam int PER  = 4 * H;
    localparam int SH   = FW + HL + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode_sel;
    logic [2:0]    spread_code;
    logic [DW-1:0] nominal_div;
    logic          mod_tick;
    logic [DW-1:0] div_out;
    logic          spread_active;
    logic          test_mode;
    logic          outputs_tristate;

    int checks   = 0;
    int failures = 0;
    int q        = 0;

    always #4 clk = ~clk;

    spread_profile_ctrl #(.DIV_W(DW), .HALF_LOG2(HL), .FRAC_W(FW)) u_dut (
        .clk              (clk),
        .rst              (rst),
        .mode_sel         (mode_sel),
        .spread_code      (spread_code),
        .nominal_div      (nominal_div),
        .mod_tick         (mod_tick),
        .div_out          (div_out),
        .spread_active    (spread_active),
        .test_mode        (test_mode),
        .outputs_tristate (outputs_tristate)
    );

    function automatic int exp_div(int nom, int code, int ph);
        int  bp;
        int  f;
        int  mag;
        bit  neg;
        longint dev;
        case (code % 4)
            0:       bp = 150;
            1:       bp = 100;
            2:       bp = 70;
            default: bp = 50;
        endcase
        f = (bp * 65536 + 5000) / 10000;
        if (code >= 4) begin
            mag = (ph <= 2 * H) ? ph : PER - ph;
            neg = 1'b1;
        end else if (ph <= H) begin
            mag = ph;       neg = 1'b0;
        end else if (ph <= 2 * H) begin
            mag = 2 * H - ph; neg = 1'b0;
        end else if (ph <= 3 * H) begin
            mag = ph - 2 * H; neg = 1'b1;
        end else begin
            mag = PER - ph; neg = 1'b1;
        end
        dev = (longint'(nom) * f * mag + (longint'(1) << (SH - 1))) >> SH;
        return neg ? nom - int'(dev) : nom + int'(dev);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [2:0] c);
        @(negedge clk);
        mode_sel    = m;
        spread_code = c;
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        mod_tick = 1'b1;
        @(negedge clk);
        mod_tick = 1'b0;
    endtask

    initial begin
        rst         = 1'b1;
        mode_sel    = 2'b00;
        spread_code = 3'b111;
        nominal_div = 12'd1000;
        mod_tick    = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 div in reset", int'(div_out), 1000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 div", int'(div_out), 1000);
        check("R1 flags", int'({test_mode, spread_active, outputs_tristate}), 0);

        // Non-spread modes: flag decode and pass-through
        set_cfg(2'b01, 3'b010);
        check("R2 mode 01 flags", int'({test_mode, spread_active, outputs_tristate}), 4);
        pulse_tick();
        pulse_tick();
        check("R3 ticks ignored in test mode", int'(div_out), 1000);
        set_cfg(2'b11, 3'b101);
        check("R2 mode 11 flags", int'({test_mode, spread_active, outputs_tristate}), 1);
        pulse_tick();
        check("R3 ticks ignored in tri-state", int'(div_out), 1000);
        set_cfg(2'b00, 3'b000);
        check("R2 mode 00 flags", int'({test_mode, spread_active, outputs_tristate}), 0);
        pulse_tick();
        check("R3 code ignored in plain mode", int'(div_out), 1000);

        // Full sweeps: every code, several nominals, wrap included
        for (int c = 0; c < 8; c++) begin
            set_cfg(2'b00, 3'(c));
            set_cfg(2'b10, 3'(c));
            q = 0;
            check("R2 mode 10 flags", int'({test_mode, spread_active, outputs_tristate}), 2);
            for (int n = 0; n < 3; n++) begin
                int nom;
                nom = (n == 0) ? 4000 : (n == 1) ? 1000 : 2711;
                @(negedge clk);
                nominal_div = DW'(nom);
                @(negedge clk);
                check("R9 nominal change", int'(div_out), exp_div(nom, c, q));
                for (int k = 0; k <= PER; k++) begin
                    pulse_tick();
                    q = (q + 1) % PER;
                    if (q == 0)
                        check("R4 wrap", int'(div_out), exp_div(nom, c, q));
                    else if (q == H || q == 2 * H)
                        check("R7 peak width", int'(div_out), exp_div(nom, c, q));
                    else if (c >= 4)
                        check("R5 down sweep", int'(div_out), exp_div(nom, c, q));
                    else
                        check("R6 centre sweep", int'(div_out), exp_div(nom, c, q));
                end
            end
        end

        // Restart by code change with a tick in the same cycle
        nominal_div = 12'd2000;
        set_cfg(2'b10, 3'b000);
        for (int k = 0; k < 5; k++) pulse_tick();
        check("R4 five steps", int'(div_out), exp_div(2000, 0, 5));
        @(negedge clk);
        spread_code = 3'b001;
        mod_tick    = 1'b1;
        @(negedge clk);
        mod_tick = 1'b0;
        check("R8 restart on code change", int'(div_out), 2000);
        pulse_tick();
        check("R8 first step after restart", int'(div_out), exp_div(2000, 1, 1));

        // Restart by leaving and re-entering spread mode
        for (int k = 0; k < 3; k++) pulse_tick();
        set_cfg(2'b00, 3'b001);
        set_cfg(2'b10, 3'b001);
        check("R8 restart on mode change", int'(div_out), 2000);

        // Nominal change mid-sweep keeps the phase
        for (int k = 0; k < 4; k++) pulse_tick();
        @(negedge clk);
        nominal_div = 12'd3000;
        @(negedge clk);
        check("R9 same phase new nominal", int'(div_out), exp_div(3000, 1, 4));
        pulse_tick();
        check("R9 sweep continues", int'(div_out), exp_div(3000, 1, 5));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule